// File: doc/BRIEF.md
# Overlay Alpha and Background Fill Selector

This block sits behind the display timing generator and, on every pixel clock, settles two things for the overlay path: which foreground alpha the first channel presents to the blender, and what color each channel shows. Channel 1 either carries its own per-pixel alpha or a global alpha taken from the control word. Any channel whose window flag is low shows a programmed background color in place of its pixel. The arithmetic blend that follows is a separate block.

Configuration arrives as single-cycle writes into a shadow copy. A context-load pulse moves the whole shadow set into the active copy at once, so a frame never sees half-applied settings. The alpha and color outputs are registered with one cycle of latency. The control fields read by the blender come straight from the active control word.

Top module: `fg_alpha_bg_select`

## Requirements
- R1: After reset the active and shadow control words are 0xFF000088: global alpha 255 in bits 31:24, overlay mode (bit 3) and video-alpha source (bit 7) set, alpha select (bit 10) clear, swap code (bits 14:12) 0. All background colors reset to 0, and `alpha_out` and `col_out` reset to 0.
- R2: A write (`cfg_we` high) with `cfg_sel` 0 lands in the shadow control word. A write with `cfg_sel` n (1 to 3) lands in the shadow background of channel n. Until a context load, no output changes because of a write.
- R3: When `ctx_load` is high, every shadow register is copied into its active register at that clock edge. A write in the same cycle is included in the copy.
- R4: With active bit 10 at 0 and channel 1 inside its window, `alpha_out` is the active control bits 31:24.
- R5: With active bit 10 at 1 and channel 1 inside its window, `alpha_out` is `pix_alpha`.
- R6: With channel 1 outside its window (`win_act[0]` low), `alpha_out` is 0.
- R7: For each channel n, its 30-bit slice of `col_out` is that channel's `pix_in` slice while its window flag is high, and its active background color while the flag is low. Colors are packed as R/Y in 29:20, G/U in 19:10 and B/V in 9:0. Channel 1 occupies bits 29:0 of the buses, channel 2 bits 59:30 and channel 3 bits 89:60.
- R8: `alpha_out` does not depend on the window flags or pixels of channels 2 and 3.
- R9: `alpha_out` and `col_out` reflect the inputs and active registers of the previous clock cycle.
- R10: `swap_code`, `ovl_mode` and `vid_alpha_sel` show active control bits 14:12, 3 and 7. Code 5 means swapped component order and code 0 means native order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Target: 0 control, 1..3 background of channel 1..3 |
| cfg_wdata | input | 32 | Write data |
| ctx_load | input | 1 | Shadow-to-active transfer pulse |
| win_act | input | 3 | Per-channel inside-window flags, bit 0 is channel 1 |
| pix_alpha | input | 8 | Per-pixel alpha of channel 1 |
| pix_in | input | 90 | Packed pixel colors of channels 1..3 |
| alpha_out | output | 8 | Selected channel-1 foreground alpha |
| col_out | output | 90 | Packed pixel-or-background colors of channels 1..3 |
| swap_code | output | 3 | Active component-swap code |
| ovl_mode | output | 1 | Active overlay data mode bit |
| vid_alpha_sel | output | 1 | Active blender video-alpha source bit |

## Verification
The bench writes settings without loading them and checks that the outputs hold; a design that wrote straight into the active copy would change alpha or background in mid-frame. It issues a write and a load in the same cycle, which catches a transfer that copies the stale shadow value. It moves the window flags of channels 2 and 3 while channel 1 stays inside, which exposes an alpha that leaks across channels. It also drives channel 1 outside its window with pixel alpha selected, so a design that forgot to force zero would pass the pixel's alpha through.

// File: rtl/fg_alpha_bg_select.sv
module fg_alpha_bg_select #(
  parameter int AW  = 8,
  parameter int CW  = 10,
  parameter int NCH = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_we,
  input  logic [$clog2(NCH+1)-1:0]   cfg_sel,
  input  logic [31:0]                cfg_wdata,
  input  logic                       ctx_load,
  input  logic [NCH-1:0]             win_act,
  input  logic [AW-1:0]              pix_alpha,
  input  logic [NCH*3*CW-1:0]        pix_in,
  output logic [AW-1:0]              alpha_out,
  output logic [NCH*3*CW-1:0]        col_out,
  output logic [2:0]                 swap_code,
  output logic                       ovl_mode,
  output logic                       vid_alpha_sel
);
  localparam int PW = 3 * CW;
  localparam int SW = $clog2(NCH + 1);
  localparam logic [31:0] CTL_RST = 32'hFF00_0088;

  logic [31:0]       ctl_sh, ctl_act, ctl_nx;
  logic [NCH*PW-1:0] bg_act_flat;
  logic [AW-1:0]     alpha_q;
  logic [NCH*PW-1:0] col_q;

  assign ctl_nx = (cfg_we && cfg_sel == '0) ? cfg_wdata : ctl_sh;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_sh  <= CTL_RST;
      ctl_act <= CTL_RST;
    end else begin
      ctl_sh <= ctl_nx;
      if (ctx_load) ctl_act <= ctl_nx;
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [PW-1:0] bg_sh, bg_act, bg_nx;
    assign bg_nx = (cfg_we && cfg_sel == SW'(g + 1)) ? cfg_wdata[PW-1:0] : bg_sh;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        bg_sh  <= '0;
        bg_act <= '0;
        col_q[g*PW +: PW] <= '0;
      end else begin
        bg_sh <= bg_nx;
        if (ctx_load) bg_act <= bg_nx;
        col_q[g*PW +: PW] <= win_act[g] ? pix_in[g*PW +: PW] : bg_act;
      end
    end
    assign bg_act_flat[g*PW +: PW] = bg_act;
  end

  wire [AW-1:0] glb_alpha = ctl_act[31 -: AW];
  wire          use_pix   = ctl_act[10];

  always_ff @(posedge clk) begin
    if (!rst_n)          alpha_q <= '0;
    else if (!win_act[0]) alpha_q <= '0;
    else                 alpha_q <= use_pix ? pix_alpha : glb_alpha;
  end

  assign alpha_out     = alpha_q;
  assign col_out       = col_q;
  assign swap_code     = ctl_act[14:12];
  assign ovl_mode      = ctl_act[3];
  assign vid_alpha_sel = ctl_act[7];

  logic unused_ctl;
  assign unused_ctl = ^{ctl_act[31-AW:15], ctl_act[11], ctl_act[9:8], ctl_act[6:4], ctl_act[2:0]};
endmodule

// File: rtl/fg_alpha_bg_select_chk.sv
module fg_alpha_bg_select_chk #(
  parameter int AW  = 8,
  parameter int CW  = 10,
  parameter int NCH = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic                ctx_load,
  input logic [NCH-1:0]      win_act,
  input logic [AW-1:0]       pix_alpha,
  input logic [NCH*3*CW-1:0] pix_in,
  input logic [AW-1:0]       alpha_out,
  input logic [NCH*3*CW-1:0] col_out,
  input logic [31:0]         ctl_act,
  input logic [NCH*3*CW-1:0] bg_act_flat
);
  localparam int PW = 3 * CW;

  a_r2_hold_without_load: assert property (@(posedge clk) disable iff (!rst_n)
    !ctx_load |=> ($stable(ctl_act) && $stable(bg_act_flat)));

  a_r4_global_alpha: assert property (@(posedge clk) disable iff (!rst_n)
    (win_act[0] && !ctl_act[10]) |=> alpha_out == $past(ctl_act[31 -: AW]));

  a_r5_pixel_alpha: assert property (@(posedge clk) disable iff (!rst_n)
    (win_act[0] && ctl_act[10]) |=> alpha_out == $past(pix_alpha));

  a_r6_outside_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !win_act[0] |=> alpha_out == '0);

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    a_r7_bg_fill: assert property (@(posedge clk) disable iff (!rst_n)
      !win_act[g] |=> col_out[g*PW +: PW] == $past(bg_act_flat[g*PW +: PW]));
    a_r7_pass: assert property (@(posedge clk) disable iff (!rst_n)
      win_act[g] |=> col_out[g*PW +: PW] == $past(pix_in[g*PW +: PW]));
  end
endmodule

bind fg_alpha_bg_select fg_alpha_bg_select_chk #(.AW(AW), .CW(CW), .NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctx_load(ctx_load), .win_act(win_act),
  .pix_alpha(pix_alpha), .pix_in(pix_in), .alpha_out(alpha_out), .col_out(col_out),
  .ctl_act(ctl_act), .bg_act_flat(bg_act_flat)
);

// File: tb/fg_alpha_bg_select_test.sv
module fg_alpha_bg_select_test;
  localparam int PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic        cfg_we = 0, ctx_load = 0;
  logic [1:0]  cfg_sel = 0;
  logic [31:0] cfg_wdata = 0;
  logic [2:0]  win_act = 0;
  logic [7:0]  pix_alpha = 0;
  logic [89:0] pix_in = 0;
  logic [7:0]  alpha_out;
  logic [89:0] col_out;
  logic [2:0]  swap_code;
  logic        ovl_mode, vid_alpha_sel;

  fg_alpha_bg_select uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .ctx_load(ctx_load), .win_act(win_act), .pix_alpha(pix_alpha), .pix_in(pix_in),
    .alpha_out(alpha_out), .col_out(col_out), .swap_code(swap_code),
    .ovl_mode(ovl_mode), .vid_alpha_sel(vid_alpha_sel)
  );

  always #(PERIOD/2) clk = ~clk;

  typedef struct {
    logic [7:0]  alpha;
    logic [89:0] col;
    logic [2:0]  swap;
    logic        ovl;
    logic        vsel;
    string       tag;
  } exp_t;

  exp_t q[$];
  int tests = 0, fails = 0;
  logic [31:0] m_sh[4], m_act[4];

  task automatic step(input logic we, input logic [1:0] sel, input logic [31:0] wd,
                      input logic ld, input logic [2:0] win, input logic [7:0] pa,
                      input logic [29:0] p1, input logic [29:0] p2, input logic [29:0] p3,
                      input string tag);
    exp_t e;
    logic [29:0] pp[3];
    @(negedge clk);
    cfg_we = we; cfg_sel = sel; cfg_wdata = wd; ctx_load = ld;
    win_act = win; pix_alpha = pa; pix_in = {p3, p2, p1};
    pp[0] = p1; pp[1] = p2; pp[2] = p3;
    e.alpha = !win[0] ? 8'd0 : (m_act[0][10] ? pa : m_act[0][31:24]);
    for (int c = 0; c < 3; c++)
      e.col[c*30 +: 30] = win[c] ? pp[c] : m_act[c+1][29:0];
    if (we) m_sh[sel] = (sel == 0) ? wd : {2'b00, wd[29:0]};
    if (ld) for (int i = 0; i < 4; i++) m_act[i] = m_sh[i];
    e.swap = m_act[0][14:12]; e.ovl = m_act[0][3]; e.vsel = m_act[0][7];
    e.tag = tag;
    q.push_back(e);
  endtask

  initial begin
    forever begin
      @(posedge clk); #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        tests++;
        if (alpha_out !== e.alpha || col_out !== e.col || swap_code !== e.swap ||
            ovl_mode !== e.ovl || vid_alpha_sel !== e.vsel) begin
          fails++;
          $display("FAIL %s: got a=%h col=%h sw=%0d ovl=%b vs=%b exp a=%h col=%h sw=%0d ovl=%b vs=%b",
                   e.tag, alpha_out, col_out, swap_code, ovl_mode, vid_alpha_sel,
                   e.alpha, e.col, e.swap, e.ovl, e.vsel);
        end
      end
    end
  end

  initial begin
    #(PERIOD*100000);
    fails++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    m_sh[0] = 32'hFF00_0088; m_act[0] = 32'hFF00_0088;
    for (int i = 1; i < 4; i++) begin m_sh[i] = 0; m_act[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R1 reset state
    tests++;
    if (alpha_out !== 0 || col_out !== 0 || swap_code !== 0 || ovl_mode !== 1 || vid_alpha_sel !== 1) begin
      fails++;
      $display("FAIL R1: got a=%h col=%h sw=%0d ovl=%b vs=%b exp a=0 col=0 sw=0 ovl=1 vs=1",
               alpha_out, col_out, swap_code, ovl_mode, vid_alpha_sel);
    end
    step(0, 0, 0, 0, 3'b111, 8'h12, 30'h1, 30'h2, 30'h3, "R1 R4 default global 255");
    step(1, 0, 32'h4000_5000, 0, 3'b111, 8'h12, 30'h11, 30'h22, 30'h33, "R2 ctl write no load");
    step(1, 1, 32'hC00F_FC01, 0, 3'b110, 8'h12, 30'h11, 30'h22, 30'h33, "R2 bg write no load");
    step(0, 0, 0, 1, 3'b111, 8'h34, 30'h44, 30'h55, 30'h66, "R3 load cycle old values");
    step(0, 0, 0, 0, 3'b111, 8'h34, 30'h44, 30'h55, 30'h66, "R4 R10 new global alpha 40");
    step(0, 0, 0, 0, 3'b110, 8'h34, 30'h44, 30'h55, 30'h66, "R6 R7 ch1 outside bg");
    step(1, 2, 32'h2AAA_5555, 0, 3'b111, 8'h34, 30'h7, 30'h8, 30'h9, "R2 bg2 write");
    step(1, 3, 32'h1234_5678, 1, 3'b111, 8'h34, 30'h7, 30'h8, 30'h9, "R3 write and load same cycle");
    step(0, 0, 0, 0, 3'b001, 8'h34, 30'hA, 30'hB, 30'hC, "R7 R8 ch2 ch3 bg alpha held");
    step(0, 0, 0, 0, 3'b101, 8'h34, 30'hA, 30'hB, 30'hC, "R7 R8 ch2 outside only");
    step(1, 0, 32'h1000_0400, 1, 3'b111, 8'h77, 30'hD, 30'hE, 30'hF, "R3 R10 alpha sel load");
    step(0, 0, 0, 0, 3'b111, 8'h7E, 30'hD, 30'hE, 30'hF, "R5 pixel alpha 7E");
    step(0, 0, 0, 0, 3'b111, 8'hFF, 30'h3FFFFFFF, 30'h0, 30'h3FFFFFFF, "R5 R9 pixel alpha FF");
    step(0, 0, 0, 0, 3'b111, 8'h00, 30'h1, 30'h2, 30'h3, "R5 pixel alpha 00");
    step(0, 0, 0, 0, 3'b110, 8'hA5, 30'h1, 30'h2, 30'h3, "R6 outside with pixel alpha");
    step(0, 0, 0, 0, 3'b001, 8'hA5, 30'h1, 30'h2, 30'h3, "R8 ch2 ch3 out pixel alpha");
    step(1, 0, 32'hFF00_5000, 0, 3'b111, 8'h5A, 30'h4, 30'h5, 30'h6, "R2 swap write pending");
    step(0, 0, 0, 1, 3'b111, 8'h5A, 30'h4, 30'h5, 30'h6, "R3 R10 swap 5 ovl vsel clear");
    step(0, 0, 0, 0, 3'b000, 8'h5A, 30'h4, 30'h5, 30'h6, "R7 all outside");
    step(1, 0, 32'h8000_0088, 1, 3'b111, 8'h5A, 30'h4, 30'h5, 30'h6, "R10 swap 0 native");
    step(0, 0, 0, 0, 3'b111, 8'h5A, 30'h4, 30'h5, 30'h6, "R4 global alpha 80");
    repeat (3) @(posedge clk);
    #2;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule